// File: doc/BRIEF.md
# Key-Locked System Control Register File

This block is a bank of 32-bit control words behind a simple register bus. The bus carries a byte address within a 4 KiB window, a write strobe with write data, and a read strobe. Read data and an error pulse come back one cycle later. Each word is addressed by the byte offset divided by four. Words past the implemented count read as zero.

A one-bit protection key guards the low part of the map. While the key is shut, writes to the guarded span are discarded. The key word itself and everything from offset 0x104 upward stay writable. A handful of offsets follow their own write rules:
- a strap word that a revision-B part can only set bits in;
- a revision offset that clears strap bits;
- read-only status words;
- a write-only word that flags reads;
- a random-data word that produces a new value on every read.

A static mode input picks the revision-A or revision-B behaviour and its reset defaults.

The key is a two-state machine with the states KEY_SHUT and KEY_OPEN. Reset enters KEY_OPEN when `key_init` is 1 and KEY_SHUT otherwise. A write of the magic value to offset 0x000 takes the transition to KEY_OPEN from either state. A write of any other value to offset 0x000 takes the transition to KEY_SHUT from either state. No other access moves the machine.

Top module: `sysctl_regfile`

## Requirements
- R1: An access is valid only when the low two address bits are 0 and the word index (address bits 11:2) is below NUM_REGS (default 106). An invalid read returns 0, and an invalid write changes nothing. Both raise the error pulse.
- R2: A write to offset 0x000 sets the key to 1 when the data equals KEY_MAGIC and to 0 for any other data. A read of 0x000 returns the key in bit 0, with bits 31:1 at zero.
- R3: While the key is 0, writes to offsets 0x004 through 0x100 are discarded and raise the error pulse. Writes to 0x000 and to offsets 0x104 and above are always accepted, and a plain accepted word reads back exactly what was written.
- R4: A write to the strap word at 0x070 ORs the data into the stored value in revision-B mode (`mode_rev_b`=1), and overwrites it in revision-A mode.
- R5: In revision-B mode, a write to 0x07C clears each strap-word bit whose data bit is 1. In revision-A mode, that write is rejected with the error pulse. The word at 0x07C never changes through the bus.
- R6: Writes to 0x014, 0x050 through 0x06C, 0x078, 0x0E0 and 0x0E4 are rejected with the error pulse and leave those words unchanged.
- R7: A read of 0x078 returns the current state of a 32-bit LFSR and then advances it by one step. The state is seeded with SEED at reset, and one step maps s to {s[30:0], s[31]^s[21]^s[1]^s[0]}. The control word at 0x074 has no effect on this.
- R8: Reset loads these defaults and zero everywhere else:
  - 0x004 = FFCFFEDC
  - 0x024 = 00000291 in revision A, 93000400 in revision B
  - 0x074 = 0000000E
  - 0x08C = 000000FF in revision A, 00000000 in revision B
  - 0x0E0 = 000000FF
  - 0x0E4 = 000000FF

  Reset then loads 0x070 from `strap1_init`, 0x0D0 from `strap2_init`, 0x07C from `rev_init` and the key from `key_init`.
- R9: A read of 0x0C0 returns the stored word and raises the error pulse. Writes to 0x0C0 are ordinary.
- R10: Read data and the error pulse appear in the cycle after the access. The error pulse lasts one cycle per rejected access and is 0 otherwise. The read data holds its value between reads and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rev_b | input | 1 | 1 selects revision-B behaviour, 0 selects revision-A behaviour |
| key_init | input | 1 | Key value loaded at reset |
| strap1_init | input | 32 | Strap word 0x070 value at reset |
| strap2_init | input | 32 | Strap word 0x0D0 value at reset |
| rev_init | input | 32 | Revision word 0x07C value at reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_err | output | 1 | One-cycle error pulse for a rejected access |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that `mode_rev_b` and the reset-load ports hold steady outside reset, and that no read or write is issued while reset is low. The bench keeps within these limits in three ways:
- it issues one access at a time, followed by an idle cycle;
- it changes the mode and the load ports only while reset is held;
- it keeps both strobes low during reset.

The sweeps walk every aligned offset of the 4 KiB window in both modes, with the key shut and with it open. Directed accesses cover unaligned addresses, strap set and clear, and the random-data word.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic {
        KEY_SHUT = 1'b0,
        KEY_OPEN = 1'b1
    } key_state_t;

    // word indices whose special handling is part of the behaviour
    localparam int unsigned W_KEY      = 0;
    localparam int unsigned W_FREQ_EVL = 5;
    localparam int unsigned W_SCR_LO   = 20;
    localparam int unsigned W_SCR_HI   = 27;
    localparam int unsigned W_STRAP1   = 28;
    localparam int unsigned W_RNG      = 30;
    localparam int unsigned W_REV      = 31;
    localparam int unsigned W_WO       = 48;
    localparam int unsigned W_STRAP2   = 52;
    localparam int unsigned W_FCNT_A   = 56;
    localparam int unsigned W_FCNT_B   = 57;
    localparam int unsigned W_LOCK_END = 65;
    localparam int unsigned RNG_W      = 32;

    function automatic logic [31:0] default_word(int unsigned idx, logic rev_b);
        logic [31:0] v;
        unique case (idx)
            1:       v = 32'hFFCF_FEDC;
            9:       v = rev_b ? 32'h9300_0400 : 32'h0000_0291;
            29:      v = 32'h0000_000E;
            35:      v = rev_b ? 32'h0000_0000 : 32'h0000_00FF;
            56, 57:  v = 32'h0000_00FF;
            default: v = 32'h0000_0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_REGS = 106,
    parameter int unsigned IDX_W    = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit,
    output logic              is_key,
    output logic              in_lock_win,
    output logic              is_ro,
    output logic              is_strap1,
    output logic              is_rev,
    output logic              is_rng,
    output logic              is_wo
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [31:0] word32;

    always_comb begin
        word32      = {{(32-WORD_W){1'b0}}, addr[ADDR_W-1:2]};
        idx         = addr[IDX_W+1:2];
        hit         = (addr[1:0] == 2'b00) && (word32 < NUM_REGS);
        is_key      = hit && (word32 == W_KEY);
        in_lock_win = hit && (word32 > W_KEY) && (word32 < W_LOCK_END);
        is_strap1   = hit && (word32 == W_STRAP1);
        is_rev      = hit && (word32 == W_REV);
        is_rng      = hit && (word32 == W_RNG);
        is_wo       = hit && (word32 == W_WO);
        is_ro       = hit && ((word32 == W_FREQ_EVL) ||
                              ((word32 >= W_SCR_LO) && (word32 <= W_SCR_HI)) ||
                              (word32 == W_RNG) ||
                              (word32 == W_FCNT_A) || (word32 == W_FCNT_B));
    end

endmodule

// File: rtl/sysctl_key_fsm.sv
module sysctl_key_fsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_init,
    input  logic key_wr,
    input  logic key_match,
    output logic key_open
);
    key_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= key_init ? KEY_OPEN : KEY_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_SHUT: if (key_wr && key_match)  state_d = KEY_OPEN;
            KEY_OPEN: if (key_wr && !key_match) state_d = KEY_SHUT;
            default:  state_d = KEY_SHUT;
        endcase
    end

    always_comb begin
        key_open = (state_q == KEY_OPEN);
    end

endmodule

// File: rtl/sysctl_lfsr.sv
module sysctl_lfsr
    import sysctl_pkg::*;
#(
    parameter logic [RNG_W-1:0] SEED = 32'hACE1_2024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [RNG_W-1:0] value
);
    logic [RNG_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    lfsr_q <= SEED;
        else if (step) lfsr_q <= {lfsr_q[RNG_W-2:0],
                                  lfsr_q[31] ^ lfsr_q[21] ^ lfsr_q[1] ^ lfsr_q[0]};
    end

    assign value = lfsr_q;

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_REGS  = 106,
    parameter logic [31:0] KEY_MAGIC = 32'h1688_A8A8,
    parameter logic [31:0] SEED      = 32'hACE1_2024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_rev_b,
    input  logic              key_init,
    input  logic [31:0]       strap1_init,
    input  logic [31:0]       strap2_init,
    input  logic [31:0]       rev_init,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_err
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0] idx;
    logic hit, is_key, in_lock_win, is_ro, is_strap1, is_rev, is_rng, is_wo;
    logic key_open;
    logic [31:0] rng_word;
    logic [31:0] regs_q [NUM_REGS];
    logic wr_reject, wr_commit, rd_reject;
    logic [31:0] rd_word;

    sysctl_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
    ) u_dec (
        .addr(bus_addr), .idx(idx), .hit(hit), .is_key(is_key),
        .in_lock_win(in_lock_win), .is_ro(is_ro), .is_strap1(is_strap1),
        .is_rev(is_rev), .is_rng(is_rng), .is_wo(is_wo)
    );

    sysctl_key_fsm u_key (
        .clk(clk), .rst_n(rst_n), .key_init(key_init),
        .key_wr(bus_wr && is_key), .key_match(bus_wdata == KEY_MAGIC),
        .key_open(key_open)
    );

    sysctl_lfsr #(.SEED(SEED)) u_rng (
        .clk(clk), .rst_n(rst_n), .step(bus_rd && is_rng), .value(rng_word)
    );

    function automatic logic [31:0] boot_word(int unsigned i);
        if (i == W_STRAP1)      return strap1_init;
        else if (i == W_STRAP2) return strap2_init;
        else if (i == W_REV)    return rev_init;
        else                    return default_word(i, mode_rev_b);
    endfunction

    // write acceptance, in priority order: range, key, lock, special words
    always_comb begin
        wr_reject = 1'b0;
        if (bus_wr) begin
            if (!hit)                          wr_reject = 1'b1;
            else if (is_key)                   wr_reject = 1'b0;
            else if (in_lock_win && !key_open) wr_reject = 1'b1;
            else if (is_rev)                   wr_reject = !mode_rev_b;
            else if (is_ro)                    wr_reject = 1'b1;
        end
        wr_commit = bus_wr && hit && !is_key && !wr_reject;
        rd_reject = bus_rd && (!hit || is_wo);
    end

    always_comb begin
        if (!hit)        rd_word = '0;
        else if (is_key) rd_word = {31'b0, key_open};
        else if (is_rng) rd_word = rng_word;
        else             rd_word = regs_q[idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int unsigned i = 0; i < NUM_REGS; i++) regs_q[i] <= boot_word(i);
        end else if (wr_commit) begin
            if (is_rev)
                regs_q[W_STRAP1] <= regs_q[W_STRAP1] & ~bus_wdata;
            else if (is_strap1)
                regs_q[idx] <= mode_rev_b ? (regs_q[idx] | bus_wdata) : bus_wdata;
            else
                regs_q[idx] <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            if (bus_rd) bus_rdata <= rd_word;
            bus_err <= wr_reject || rd_reject;
        end
    end

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_REGS  = 106,
    parameter logic [31:0] KEY_MAGIC = 32'h1688_A8A8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              key_open
);
    logic [31:0] word32;
    logic        bad_addr;
    assign word32   = {{(34-ADDR_W){1'b0}}, bus_addr[ADDR_W-1:2]};
    assign bad_addr = (bus_addr[1:0] != 2'b00) || (word32 >= NUM_REGS);

    AST_KEY_READ_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_addr == '0) |=> (bus_rdata[31:1] == 31'b0)); // R2

    AST_MAGIC_OPENS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == '0) && (bus_wdata == KEY_MAGIC) |=> key_open); // R2

    AST_LOCKED_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !key_open && (bus_addr >= ADDR_W'(4)) && (bus_addr <= ADDR_W'(256))
        |=> bus_err); // R3

    AST_RNG_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_addr == ADDR_W'(120)) |=> (bus_rdata != 32'b0)); // R7

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !bus_wr && bad_addr |=> bus_err && (bus_rdata == 32'b0)); // R1

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd || bus_wr)); // R10

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata)); // R10

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .KEY_MAGIC(KEY_MAGIC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .key_open(key_open)
);

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;
    localparam int unsigned NUM   = 106;
    localparam logic [31:0] MAGIC = 32'h1688_A8A8;
    localparam logic [31:0] SEED  = 32'hACE1_2024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_rev_b = 1'b0, key_init = 1'b0;
    logic [31:0] strap1_init = 32'h0F0F_1234, strap2_init = 32'h0055_AA00;
    logic [31:0] rev_init = 32'h0201_0303;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_mem [NUM];
    logic        m_key;
    logic [31:0] m_lfsr;

    always #10 clk = ~clk;

    sysctl_regfile #(.NUM_REGS(NUM), .KEY_MAGIC(MAGIC), .SEED(SEED)) u_sysctl_regfile (
        .clk(clk), .rst_n(rst_n), .mode_rev_b(mode_rev_b), .key_init(key_init),
        .strap1_init(strap1_init), .strap2_init(strap2_init), .rev_init(rev_init),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    function automatic logic [31:0] dflt(int w, logic revb);
        case (w)
            1:       return 32'hFFCF_FEDC;
            9:       return revb ? 32'h9300_0400 : 32'h0000_0291;
            29:      return 32'h0000_000E;
            35:      return revb ? 32'h0000_0000 : 32'h0000_00FF;
            56, 57:  return 32'h0000_00FF;
            28:      return strap1_init;
            31:      return rev_init;
            52:      return strap2_init;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic ro_word(int w);
        return (w == 5) || (w >= 20 && w <= 27) || (w == 30) || (w == 56) || (w == 57);
    endfunction

    task automatic check(input string tag, input logic [11:0] a,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, act, exp);
        end
    endtask

    task automatic do_reset(input logic revb, input logic kinit);
        rst_n = 1'b0;
        mode_rev_b = revb;
        key_init = kinit;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NUM; i++) m_mem[i] = dflt(i, revb);
        m_key  = kinit;
        m_lfsr = SEED;
        rst_n  = 1'b1;
        @(negedge clk);
        check("R10 rdata after reset", 12'h0, bus_rdata, 32'h0);
        check("R10 err after reset", 12'h0, {31'b0, bus_err}, 32'h0);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        logic  exp_err;
        string tag;
        int    w;
        w = int'(a[11:2]);
        if (a[1:0] != 2'b00 || w >= NUM) begin exp_err = 1'b1; tag = "R1 write"; end
        else if (w == 0) begin m_key = (d == MAGIC); exp_err = 1'b0; tag = "R2 write"; end
        else if (w < 65 && !m_key) begin exp_err = 1'b1; tag = "R3 locked write"; end
        else if (w == 31) begin
            tag = "R5 write";
            if (mode_rev_b) begin m_mem[28] = m_mem[28] & ~d; exp_err = 1'b0; end
            else exp_err = 1'b1;
        end
        else if (w == 28) begin
            tag = "R4 write";
            m_mem[28] = mode_rev_b ? (m_mem[28] | d) : d;
            exp_err = 1'b0;
        end
        else if (ro_word(w)) begin exp_err = 1'b1; tag = "R6 write"; end
        else begin m_mem[w] = d; exp_err = 1'b0; tag = (w == 48) ? "R9 write" : "R3 write"; end
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(tag, a, {31'b0, bus_err}, {31'b0, exp_err});
        @(negedge clk);
        check("R10 err one cycle", a, {31'b0, bus_err}, 32'h0);
    endtask

    task automatic bus_read(input logic [11:0] a, input string dtag);
        logic [31:0] exp_d;
        logic        exp_err;
        string       tag;
        int          w;
        w = int'(a[11:2]);
        tag = dtag; exp_err = 1'b0;
        if (a[1:0] != 2'b00 || w >= NUM) begin exp_d = 0; exp_err = 1'b1; tag = "R1 read"; end
        else if (w == 0) begin exp_d = {31'b0, m_key}; tag = "R2 read"; end
        else if (w == 30) begin
            exp_d = m_lfsr; tag = "R7 read";
            m_lfsr = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
        end
        else if (w == 48) begin exp_d = m_mem[w]; exp_err = 1'b1; tag = "R9 read"; end
        else exp_d = m_mem[w];
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, a, bus_rdata, exp_d);
        check({tag, " err"}, a, {31'b0, bus_err}, {31'b0, exp_err});
        @(negedge clk);
        check("R10 rdata holds", a, bus_rdata, exp_d);
    endtask

    task automatic sweep_read(input string tag);
        for (int a = 0; a < 4096; a += 4) bus_read(12'(a), tag);
    endtask

    task automatic sweep_write(input logic [31:0] flip);
        for (int a = 4; a < 4096; a += 4)
            bus_write(12'(a), {12'(a), 4'h5, 12'(a), 4'hA} ^ flip);
    endtask

    task automatic run_mode(input logic revb);
        do_reset(revb, 1'b0);
        sweep_read("R8 default");
        sweep_write(32'h0);
        sweep_read("R3 after locked sweep");
        bus_write(12'h000, 32'h1688_A8A9);
        bus_read(12'h000, "R2");
        bus_write(12'h000, MAGIC);
        bus_read(12'h000, "R2");
        sweep_write(32'hFFFF_0000);
        sweep_read("R3 after open sweep");
        bus_write(12'h070, 32'h0000_00F0);
        bus_read(12'h070, "R4");
        bus_write(12'h07C, 32'h0000_0030);
        bus_read(12'h070, "R5 strap");
        bus_read(12'h07C, "R5 rev word");
        bus_write(12'h074, 32'h0);
        bus_read(12'h078, "R7");
        bus_write(12'h074, 32'hFFFF_FFFF);
        bus_read(12'h078, "R7");
        bus_read(12'h078, "R7");
        bus_write(12'h105, 32'hDEAD_BEEF);
        bus_write(12'h0C2, 32'hDEAD_BEEF);
        bus_read(12'h104, "R1 unaligned no effect");
        bus_read(12'h0C0, "R1 unaligned no effect");
        bus_read(12'h106, "R1");
        bus_read(12'h1A8, "R1");
        bus_write(12'h000, 32'h0);
        bus_write(12'h040, 32'h1234_5678);
        bus_read(12'h040, "R3 locked");
        bus_write(12'h104, 32'h8765_4321);
        bus_read(12'h104, "R3 open window");
        do_reset(revb, 1'b1);
        bus_read(12'h000, "R8 key from port");
        bus_write(12'h008, 32'h5A5A_0001);
        bus_read(12'h008, "R3 key open");
    endtask

    initial begin
        run_mode(1'b0);
        strap1_init = 32'h8000_0301;
        rev_init    = 32'h0403_0303;
        run_mode(1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule